// File: doc/BRIEF.md
# Read-Once Double-Buffered Line Word Readout

This block sits behind a line decoder and holds one 40-bit decoded word in two stages. The decoder presents the word with a one-cycle strobe once the line has decoded without error. The word goes into a capture bank and is then copied into a transfer bank. A two-wire serial master reads the transfer bank as five bytes. While the slave is addressed, the copy waits, so a read never sees a word that changes part way through. The copy runs at the next START or STOP condition.

A new-data flag (`new_data`) is set by each copy. It is cleared when one read transaction has shifted out all five bytes. While the flag is clear, every byte the slave returns is 0xFF. Data can therefore be read only once. Reads made after reset and before the first good line also return all ones.

The serial side is a read-only slave with a two-flop synchronizer on both lines. It pulls SDA low through an open-drain enable. One address bit comes from a pin.

The slave controller has seven states:
- ST_IDLE: waits for START.
- ST_ADDR: shifts in the address byte on SCL rising edges.
- ST_AACK: drives the address acknowledge.
- ST_TX: shifts a data byte out MSB first, changing SDA on SCL falling edges.
- ST_MACK: samples the master's acknowledge on the SCL rising edge.
- ST_NEXT: after an acknowledge, waits for the SCL falling edge and loads the next byte.
- ST_SKIP: holds SDA released until the next START or STOP.

Transitions:
- START from any state goes to ST_ADDR.
- STOP from any state goes to ST_IDLE.
- ST_ADDR goes to ST_AACK on a matching read address, and to ST_SKIP otherwise.
- ST_AACK goes to ST_TX.
- ST_TX goes to ST_MACK after its eighth bit.
- ST_MACK goes to ST_NEXT on ACK, and to ST_SKIP on NACK.
- ST_NEXT goes to ST_TX.

Top module: `linebuf_i2c_rd`

## Requirements
- R1: After reset, `new_data` is 0, `sda_oe` is 0, and the transfer bank holds all ones, so the first read returns 0xFF in all five bytes.
- R2: The slave acknowledges only an address byte equal to {ADDR_HI[5:0], addr_sel, 1}, where the last bit is the read bit. A wrong address, or the write bit (0), gets no acknowledge, and SDA stays released for that transaction.
- R3: Bytes are sent MSB first in the order line_word[39:32], [31:24], [23:16], [15:8], [7:0].
- R4: A `line_ok` pulse while the slave is not addressed makes `new_data` 1 within 4 cycles, and the next read returns that word.
- R5: A `line_ok` pulse while the slave is addressed does not change the bytes of the ongoing read. The copy happens only after the next START or STOP, and only then is `new_data` set again.
- R6: When one transaction has shifted out all five bytes, `new_data` goes to 0 and later reads return 0xFF.
- R7: A transaction that ends before the fifth byte leaves `new_data` at 1, and a later read returns the full word.
- R8: Any byte requested after the fifth byte of a transaction is 0xFF.
- R9: After the master NACKs a byte, the slave keeps SDA released until the next START or STOP.
- R10: A second `line_ok` before a read replaces the held word with the newer one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| line_word | input | 40 | Decoded line word, first byte to send in [39:32] |
| line_ok | input | 1 | One-cycle strobe: line decoded without error |
| addr_sel | input | 1 | Address select, forms the lowest slave address bit |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain) |
| new_data | output | 1 | Unread valid word held |

## Verification
The read path is tried with several address patterns:
- A matching read address separates a good decode from a wrong address, a write bit, and a flipped select pin.
- Full five-byte reads of distinct words show byte order and bit order.
- A two-byte read ended by NACK shows that a partial read does not consume the word.
- A six-byte read shows the all-ones fill after the last byte.

A strobe that arrives in the middle of a read separates a deferred copy from an immediate one. Two strobes in a row show that the newer word replaces the older one.

// File: rtl/lb_pkg.sv
package lb_pkg;

    localparam int LB_BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_TX,
        ST_MACK,
        ST_NEXT,
        ST_SKIP
    } lb_state_t;

endpackage

// File: rtl/lb_sync.sv
module lb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int LINES = 2;

    logic [LINES-1:0]             raw;
    logic [LINES-1:0][STAGES-1:0] pipe;
    logic                         scl_s;
    logic                         scl_q;
    logic                         sda_q;

    assign raw = {scl_i, sda_i};

    // one synchronizer chain per bus line, idle level is high
    for (genvar g = 0; g < LINES; g++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pipe[g] <= '1;
            end else begin
                pipe[g] <= {pipe[g][STAGES-2:0], raw[g]};
            end
        end
    end

    assign scl_s = pipe[1][STAGES-1];
    assign sda_s = pipe[0][STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/lb_banks.sv
module lb_banks #(
    parameter int BYTES = 5,
    parameter int BW    = 8,
    parameter int IDXW  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTES*BW-1:0] line_word,
    input  logic              line_ok,
    input  logic              owned,
    input  logic              consume,
    input  logic [IDXW-1:0]   byte_idx,
    output logic [BW-1:0]     tx_byte,
    output logic              flag,
    output logic [BYTES*BW-1:0] xfer
);
    localparam int W = BYTES * BW;

    logic [W-1:0] cap;
    logic         pend;
    logic         do_copy;

    // copy waits while the slave holds the bus; owned drops at START/STOP
    assign do_copy = pend & ~owned;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap  <= '1;
            xfer <= '1;
            pend <= 1'b0;
            flag <= 1'b0;
        end else begin
            if (do_copy) begin
                xfer <= cap;
                flag <= 1'b1;
                pend <= 1'b0;
            end else if (consume) begin
                flag <= 1'b0;
            end
            if (line_ok) begin
                cap  <= line_word;
                pend <= 1'b1;
            end
        end
    end

    always_comb begin
        tx_byte = '1;
        if (flag) begin
            for (int i = 0; i < BYTES; i++) begin
                if (int'(byte_idx) == i) begin
                    tx_byte = xfer[W-1-BW*i -: BW];
                end
            end
        end
    end

endmodule

// File: rtl/lb_slave_fsm.sv
module lb_slave_fsm
    import lb_pkg::*;
#(
    parameter logic [5:0] ADDR_HI = 6'b010001,
    parameter int         BYTES   = 5,
    parameter int         IDXW    = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sda_s,
    input  logic            scl_rise,
    input  logic            scl_fall,
    input  logic            start_det,
    input  logic            stop_det,
    input  logic            addr_sel,
    input  logic [LB_BYTE_W-1:0] tx_byte,
    output logic            sda_oe,
    output logic            owned,
    output logic            consume,
    output logic [IDXW-1:0] byte_idx,
    output lb_state_t       state
);
    localparam int BW = LB_BYTE_W;
    localparam int CW = $clog2(BW + 1);
    localparam logic [CW-1:0]   LAST_BIT  = CW'(BW - 1);
    localparam logic [CW-1:0]   ADDR_DONE = CW'(BW);
    localparam logic [IDXW-1:0] IDX_MAX   = IDXW'(BYTES);
    localparam logic [IDXW-1:0] IDX_FINAL = IDXW'(BYTES - 1);

    lb_state_t     nxt;
    logic [BW-1:0] sh;
    logic [CW-1:0] bitcnt;
    logic          addr_hit;

    assign addr_hit = (sh[BW-1:1] == {ADDR_HI, addr_sel}) && sh[0];

    // next state
    always_comb begin
        nxt = state;
        if (stop_det) begin
            nxt = ST_IDLE;
        end else if (start_det) begin
            nxt = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE: nxt = ST_IDLE;
                ST_ADDR: if (scl_fall && bitcnt == ADDR_DONE)
                             nxt = addr_hit ? ST_AACK : ST_SKIP;
                ST_AACK: if (scl_fall) nxt = ST_TX;
                ST_TX:   if (scl_fall && bitcnt == LAST_BIT) nxt = ST_MACK;
                ST_MACK: if (scl_rise) nxt = sda_s ? ST_SKIP : ST_NEXT;
                ST_NEXT: if (scl_fall) nxt = ST_TX;
                ST_SKIP: nxt = ST_SKIP;
                default: nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // shift, counters and ownership
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh       <= '0;
            bitcnt   <= '0;
            byte_idx <= '0;
            owned    <= 1'b0;
        end else if (stop_det) begin
            owned <= 1'b0;
        end else if (start_det) begin
            owned    <= 1'b0;
            bitcnt   <= '0;
            byte_idx <= '0;
        end else begin
            unique case (state)
                ST_ADDR: begin
                    if (scl_rise && bitcnt != ADDR_DONE) begin
                        sh     <= {sh[BW-2:0], sda_s};
                        bitcnt <= bitcnt + 1'b1;
                    end
                    if (nxt == ST_AACK) owned <= 1'b1;
                end
                ST_AACK, ST_NEXT: begin
                    if (scl_fall) begin
                        sh     <= tx_byte;
                        bitcnt <= '0;
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (bitcnt == LAST_BIT) begin
                            if (byte_idx != IDX_MAX) byte_idx <= byte_idx + 1'b1;
                        end else begin
                            sh     <= {sh[BW-2:0], 1'b1};
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                end
                ST_IDLE, ST_MACK, ST_SKIP: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        sda_oe  = 1'b0;
        consume = 1'b0;
        unique case (state)
            ST_AACK: sda_oe = 1'b1;
            ST_TX: begin
                sda_oe  = ~sh[BW-1];
                consume = scl_fall && (bitcnt == LAST_BIT) && (byte_idx == IDX_FINAL)
                          && !stop_det && !start_det;
            end
            ST_IDLE, ST_ADDR, ST_MACK, ST_NEXT, ST_SKIP: sda_oe = 1'b0;
            default: sda_oe = 1'b0;
        endcase
    end

endmodule

// File: rtl/linebuf_i2c_rd.sv
module linebuf_i2c_rd
    import lb_pkg::*;
#(
    parameter logic [5:0] ADDR_HI     = 6'b010001,
    parameter int         NUM_BYTES   = 5,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_BYTES*LB_BYTE_W-1:0] line_word,
    input  logic                           line_ok,
    input  logic                           addr_sel,
    input  logic                           scl_i,
    input  logic                           sda_i,
    output logic                           sda_oe,
    output logic                           new_data
);
    localparam int IDXW = $clog2(NUM_BYTES + 1);

    logic                           sda_s;
    logic                           scl_rise;
    logic                           scl_fall;
    logic                           start_det;
    logic                           stop_det;
    logic                           bus_owned;
    logic                           consume;
    logic [IDXW-1:0]                byte_idx;
    logic [LB_BYTE_W-1:0]           tx_byte;
    logic [NUM_BYTES*LB_BYTE_W-1:0] xfer_bank;
    lb_state_t                      fsm_state;

    lb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    lb_slave_fsm #(.ADDR_HI(ADDR_HI), .BYTES(NUM_BYTES), .IDXW(IDXW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .addr_sel  (addr_sel),
        .tx_byte   (tx_byte),
        .sda_oe    (sda_oe),
        .owned     (bus_owned),
        .consume   (consume),
        .byte_idx  (byte_idx),
        .state     (fsm_state)
    );

    lb_banks #(.BYTES(NUM_BYTES), .BW(LB_BYTE_W), .IDXW(IDXW)) u_banks (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_word (line_word),
        .line_ok   (line_ok),
        .owned     (bus_owned),
        .consume   (consume),
        .byte_idx  (byte_idx),
        .tx_byte   (tx_byte),
        .flag      (new_data),
        .xfer      (xfer_bank)
    );

endmodule

// File: rtl/lb_checker.sv
module lb_checker
    import lb_pkg::*;
#(
    parameter int W = 40
) (
    input logic      clk,
    input logic      rst_n,
    input lb_state_t state,
    input logic      sda_oe,
    input logic      owned,
    input logic      flag,
    input logic [W-1:0] xfer
);

    // R5: transfer bank frozen while the slave stays addressed
    a_r5_bank_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (owned && $past(owned)) |-> $stable(xfer));

    // R4: new word published only when the bus was not held
    a_r4_publish_when_free: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> !$past(owned));

    // R6: flag drops only out of a byte shift
    a_r6_clear_after_shift: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> ($past(state) == ST_TX));

    // R2: no drive outside acknowledge and data slots
    a_r2_quiet_outside_slots: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_ADDR || state == ST_MACK || state == ST_NEXT)
        |-> !sda_oe);

    // R9: released after a NACK or a foreign address
    a_r9_skip_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP) |-> !sda_oe);

endmodule

bind linebuf_i2c_rd lb_checker #(.W(NUM_BYTES*lb_pkg::LB_BYTE_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .state  (fsm_state),
    .sda_oe (sda_oe),
    .owned  (bus_owned),
    .flag   (new_data),
    .xfer   (xfer_bank)
);

// File: tb/linebuf_i2c_rd_tb.sv
module linebuf_i2c_rd_tb;

    localparam int HP = 12;
    localparam logic [6:0] A0 = 7'h22;
    localparam logic [6:0] A1 = 7'h23;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [39:0] line_word = '0;
    logic        line_ok = 1'b0;
    logic        addr_sel = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic        sda_oe;
    logic        new_data;
    logic        sda_line;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;
    logic [7:0] got [0:7];

    always #4 clk = ~clk;

    assign sda_line = m_sda & ~sda_oe;

    linebuf_i2c_rd u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_word (line_word),
        .line_ok   (line_ok),
        .addr_sel  (addr_sel),
        .scl_i     (m_scl),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .new_data  (new_data)
    );

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] byte_of(input logic [39:0] w, input int i);
        return 8'((w >> (8 * (4 - i))) & 40'hFF);
    endfunction

    task automatic bus_start();
        m_sda = 1'b1; wclk(HP);
        m_scl = 1'b1; wclk(HP);
        m_sda = 1'b0; wclk(HP);
        m_scl = 1'b0; wclk(2);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wclk(HP);
        m_scl = 1'b1; wclk(HP);
        m_sda = 1'b1; wclk(HP);
    endtask

    task automatic put_bit(input logic b);
        m_sda = b; wclk(HP);
        m_scl = 1'b1; wclk(HP);
        m_scl = 1'b0; wclk(2);
    endtask

    task automatic get_bit(output logic b);
        m_sda = 1'b1; wclk(HP);
        m_scl = 1'b1; wclk(HP / 2);
        b = sda_line; wclk(HP / 2);
        m_scl = 1'b0; wclk(2);
    endtask

    task automatic put_byte(input logic [7:0] v, output logic ack);
        logic x;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(x);
        ack = ~x;
    endtask

    task automatic get_byte(input logic nack, output logic [7:0] v);
        logic x;
        for (int i = 7; i >= 0; i--) begin
            get_bit(x);
            v[i] = x;
        end
        put_bit(nack);
    endtask

    task automatic rd_txn(input logic [6:0] a, input int n, output logic ack);
        logic [7:0] v;
        bus_start();
        put_byte({a, 1'b1}, ack);
        if (ack) begin
            for (int i = 0; i < n; i++) begin
                get_byte(i == n - 1, v);
                got[i] = v;
            end
        end
        bus_stop();
    endtask

    task automatic load(input logic [39:0] w);
        @(negedge clk);
        line_word = w;
        line_ok   = 1'b1;
        @(negedge clk);
        line_ok   = 1'b0;
        wclk(4);
    endtask

    task automatic t_reset();
        logic ack;
        chk("R1 new_data", new_data, 0);
        chk("R1 sda_oe", sda_oe, 0);
        rd_txn(A0, 5, ack);
        chk("R2 ack own address", ack, 1);
        for (int i = 0; i < 5; i++) chk("R1 byte after reset", got[i], 8'hFF);
    endtask

    task automatic t_addr();
        logic ack;
        logic x;
        rd_txn(A1, 1, ack);
        chk("R2 wrong address no ack", ack, 0);
        bus_start();
        put_byte({A0, 1'b0}, ack);
        chk("R2 write bit no ack", ack, 0);
        get_bit(x);
        chk("R2 released after write", x, 1);
        bus_stop();
    endtask

    task automatic t_fresh();
        logic ack;
        logic [39:0] w = 40'hA1_5C_3E_07_F0;
        load(w);
        chk("R4 new_data set", new_data, 1);
        rd_txn(A0, 5, ack);
        for (int i = 0; i < 5; i++) chk("R3 byte order", got[i], byte_of(w, i));
        wclk(2);
        chk("R6 flag cleared", new_data, 0);
        rd_txn(A0, 5, ack);
        for (int i = 0; i < 5; i++) chk("R6 reread ones", got[i], 8'hFF);
    endtask

    task automatic t_partial();
        logic ack;
        logic x;
        logic [7:0] v0;
        logic [7:0] v1;
        logic [39:0] w = 40'h12_34_56_78_9A;
        load(w);
        bus_start();
        put_byte({A0, 1'b1}, ack);
        get_byte(1'b0, v0);
        get_byte(1'b1, v1);
        chk("R7 partial byte0", v0, byte_of(w, 0));
        chk("R7 partial byte1", v1, byte_of(w, 1));
        get_bit(x);
        chk("R9 released after nack", x, 1);
        bus_stop();
        chk("R7 flag kept", new_data, 1);
        rd_txn(A0, 5, ack);
        for (int i = 0; i < 5; i++) chk("R7 full read later", got[i], byte_of(w, i));
    endtask

    task automatic t_extra();
        logic ack;
        logic [39:0] w = 40'hDE_AD_00_BE_EF;
        load(w);
        rd_txn(A0, 6, ack);
        for (int i = 0; i < 5; i++) chk("R8 first five", got[i], byte_of(w, i));
        chk("R8 sixth byte ones", got[5], 8'hFF);
    endtask

    task automatic t_defer();
        logic ack;
        logic [7:0] v;
        logic [39:0] w_old = 40'h0F_1E_2D_3C_4B;
        logic [39:0] w_new = 40'h99_88_77_66_55;
        load(w_old);
        bus_start();
        put_byte({A0, 1'b1}, ack);
        get_byte(1'b0, v);
        chk("R5 byte0 old", v, byte_of(w_old, 0));
        load(w_new);
        for (int i = 1; i < 5; i++) begin
            get_byte(i == 4, v);
            chk("R5 old word kept", v, byte_of(w_old, i));
        end
        wclk(4);
        chk("R5 copy deferred", new_data, 0);
        bus_stop();
        wclk(4);
        chk("R5 copy after stop", new_data, 1);
        rd_txn(A0, 5, ack);
        for (int i = 0; i < 5; i++) chk("R5 new word", got[i], byte_of(w_new, i));
    endtask

    task automatic t_overwrite();
        logic ack;
        logic [39:0] w_b = 40'h01_23_45_67_89;
        load(40'hAA_BB_CC_DD_EE);
        load(w_b);
        rd_txn(A0, 5, ack);
        for (int i = 0; i < 5; i++) chk("R10 newest word", got[i], byte_of(w_b, i));
    endtask

    task automatic t_sel();
        logic ack;
        addr_sel = 1'b1;
        wclk(2);
        rd_txn(A1, 1, ack);
        chk("R2 select pin address", ack, 1);
        rd_txn(A0, 1, ack);
        chk("R2 old address refused", ack, 0);
        addr_sel = 1'b0;
    endtask

    initial begin
        wclk(5);
        rst_n = 1'b1;
        wclk(5);
        t_reset();
        t_addr();
        t_fresh();
        t_partial();
        t_extra();
        t_defer();
        t_overwrite();
        t_sel();
        done = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

endmodule